// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps an asynchronous multiplexed-address DRAM alive. After reset it holds the memory strobes idle for a programmable power-up pause. It then runs a fixed burst of refresh cycles back to back and raises `initDone` once the last of them has finished. From then on it spreads refresh cycles evenly over the retention period, so that all 1024 rows are visited in each period. An interval timer, derived from the clock frequency, raises one refresh request every period divided by the row count. The retention period is the short one by default, or a longer one selected by `slowRate`.

The sequencer shares the memory pins with an access controller. It asks for the bus on `busReq`, waits for `busGrant`, and moves RAS, the two CAS lanes and WE only while it holds the grant. Each cycle is either CAS-before-RAS, where the memory supplies the row, or RAS-only, where the sequencer drives the row from its own 10-bit counter. The `rasOnlyMode` input picks the kind, and its value is captured when the grant is taken. If the controller is busy, a due refresh stays pending. If a second interval runs out while one is still waiting, a sticky overflow flag is set.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset release `rasN`, `ucasN`, `lcasN` and `weN` stay high, `addr` is zero, `initDone` and `refreshOverflow` are low, and `busReq` stays low for at least PAUSE cycles (CLK_KHZ*PAUSE_US/1000).
- R2: After the pause exactly INIT_CYCLES (default 8) refresh cycles are run back to back. `initDone` rises only after the last of them has completed, at which point `rasN` is high and `busReq` is low. Once set, `initDone` stays high.
- R3: `rasN` falls only while `busGrant` is high, and `busReq` stays high from the request until the cycle's precharge ends.
- R4: In a CAS-before-RAS cycle only `lcasN` is driven low (`ucasN` stays high). It goes low CSR_CYC cycles before `rasN` falls and stays low for CHR_CYC cycles after that fall. `weN` stays high.
- R5: In a RAS-only cycle both CAS lanes stay high and `addr` carries the internal row counter. The counter starts at 0, advances by one after each RAS-only cycle, and wraps from 1023 to 0.
- R6: With `slowRate`=0, once initialisation is done, refresh cycles start exactly INTERVAL cycles apart, where INTERVAL = CLK_KHZ*RETENTION_US/1000/1024.
- R7: With `slowRate`=1 the spacing is INTERVAL*RATE_MUL cycles (default 8, giving the long retention period).
- R8: A refresh that falls due while the grant is withheld keeps `busReq` high, does not touch RAS, and is carried out within a few cycles of the grant arriving.
- R9: `refreshOverflow` is set when an interval expires while the previous refresh is still pending. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowRate | input | 1 | 1 selects the long retention period |
| rasOnlyMode | input | 1 | 1 selects RAS-only cycles with internal row address, 0 selects CAS-before-RAS |
| busGrant | input | 1 | Memory bus granted by the access controller |
| busReq | output | 1 | Memory bus requested |
| rasN | output | 1 | Row strobe, active low |
| ucasN | output | 1 | Upper-byte column strobe, active low |
| lcasN | output | 1 | Lower-byte column strobe, active low |
| weN | output | 1 | Write enable, active low (held high) |
| addr | output | ROW_BITS | Row address during RAS-only cycles, zero otherwise |
| initDone | output | 1 | Initialisation burst completed |
| refreshOverflow | output | 1 | Sticky: a refresh interval expired while one was still pending |

## Verification
Some rules are checked by the assertions on every cycle: RAS never falls without the grant, the CAS lane is already low in the cycle before RAS falls in a CAS-before-RAS cycle, the bus stays quiet during the pause, the row counter steps by exactly one, and both `initDone` and `refreshOverflow` hold once set. Other behaviour can only be shown by the bench scenarios. These cover the length of the pause, the count of initialisation cycles, the exact spacing at both retention rates, the row sequence and its wrap in RAS-only mode, and the pending and overflow behaviour when the grant is withheld for one interval or for two.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_REQ, ST_SETUP, ST_HOLD, ST_TAIL, ST_PRE
  } refState_t;

  typedef enum logic [1:0] {
    PH_SET, PH_HOLD, PH_TAIL, PH_PRE
  } phaseSel_t;

  typedef struct packed {
    logic      ldPhase;
    phaseSel_t phaseSel;
    logic      cycleDone;
    logic      rowStep;
    logic      addrEn;
  } refStrobe_t;

endpackage

// File: rtl/dram_ref_dp.sv
module dram_ref_dp
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYCLES = 20000,
  parameter int INTERVAL     = 1562,
  parameter int RATE_MUL     = 8,
  parameter int INIT_CYCLES  = 8,
  parameter int ROW_BITS     = 10,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_CYC      = 6,
  parameter int RP_CYC       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slowRate,
  input  refStrobe_t          strb,
  output logic                pauseDone,
  output logic                initDone,
  output logic                initLast,
  output logic                pending,
  output logic                phaseZero,
  output logic                refreshOverflow,
  output logic [ROW_BITS-1:0] addr
);

  localparam int PAUSE_W  = $clog2(PAUSE_CYCLES + 1);
  localparam int LONG_INT = INTERVAL * RATE_MUL;
  localparam int IW       = $clog2(LONG_INT + 1);
  localparam int INIT_W   = $clog2(INIT_CYCLES + 1);
  localparam int PH_MAX   = CSR_CYC + RAS_CYC + RP_CYC;
  localparam int PHW      = $clog2(PH_MAX + 1);

  // power-up pause
  logic [PAUSE_W-1:0] pauseCnt;
  assign pauseDone = (pauseCnt == PAUSE_W'(PAUSE_CYCLES));
  always_ff @(posedge clk) begin
    if (!rstN)           pauseCnt <= '0;
    else if (!pauseDone) pauseCnt <= pauseCnt + 1'b1;
  end

  // phase timer
  logic [PHW-1:0] phaseCnt;
  logic [PHW-1:0] phaseVal;
  always_comb begin
    case (strb.phaseSel)
      PH_SET:  phaseVal = PHW'(CSR_CYC - 1);
      PH_HOLD: phaseVal = PHW'(CHR_CYC - 1);
      PH_TAIL: phaseVal = PHW'(RAS_CYC - CHR_CYC - 1);
      default: phaseVal = PHW'(RP_CYC - 1);
    endcase
  end
  assign phaseZero = (phaseCnt == '0);
  always_ff @(posedge clk) begin
    if (!rstN)             phaseCnt <= '0;
    else if (strb.ldPhase) phaseCnt <= phaseVal;
    else if (!phaseZero)   phaseCnt <= phaseCnt - 1'b1;
  end

  // initialisation count
  logic [INIT_W-1:0] initCnt;
  assign initDone = (initCnt == INIT_W'(INIT_CYCLES));
  assign initLast = (initCnt == INIT_W'(INIT_CYCLES - 1));
  always_ff @(posedge clk) begin
    if (!rstN)                             initCnt <= '0;
    else if (strb.cycleDone && !initDone)  initCnt <= initCnt + 1'b1;
  end

  // refresh interval timer
  logic [IW-1:0] tick;
  logic [IW-1:0] intLimit;
  logic          expire;
  logic          serviced;
  assign intLimit = slowRate ? IW'(LONG_INT - 1) : IW'(INTERVAL - 1);
  assign expire   = initDone && (tick >= intLimit);
  assign serviced = strb.cycleDone && initDone;
  always_ff @(posedge clk) begin
    if (!rstN || !initDone) tick <= '0;
    else if (expire)        tick <= '0;
    else                    tick <= tick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending         <= 1'b0;
      refreshOverflow <= 1'b0;
    end else begin
      if (expire)        pending <= 1'b1;
      else if (serviced) pending <= 1'b0;
      if (expire && pending && !serviced) refreshOverflow <= 1'b1;
    end
  end

  // row counter for RAS-only cycles
  logic [ROW_BITS-1:0] rowCnt;
  always_ff @(posedge clk) begin
    if (!rstN)             rowCnt <= '0;
    else if (strb.rowStep) rowCnt <= rowCnt + 1'b1;
  end
  assign addr = strb.addrEn ? rowCnt : '0;

  // R2
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshOverflow |=> refreshOverflow);
  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rowStep |=> rowCnt == $past(rowCnt) + 1'b1);

endmodule

// File: rtl/dram_ref_ctl.sv
module dram_ref_ctl
  import dram_ref_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  logic       rasOnlyMode,
  input  logic       pauseDone,
  input  logic       initDone,
  input  logic       initLast,
  input  logic       pending,
  input  logic       phaseZero,
  output refStrobe_t strb,
  output logic       busReq,
  output logic       rasN,
  output logic       ucasN,
  output logic       lcasN,
  output logic       weN
);

  refState_t st, nxt;
  logic      modeRasOnly;
  logic      inCycle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st          <= ST_PAUSE;
      modeRasOnly <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_REQ && busGrant) modeRasOnly <= rasOnlyMode;
    end
  end

  assign inCycle = (st == ST_SETUP) || (st == ST_HOLD) ||
                   (st == ST_TAIL)  || (st == ST_PRE);

  always_comb begin
    nxt  = st;
    strb = '0;
    case (st)
      ST_PAUSE: if (pauseDone) nxt = ST_REQ;
      ST_IDLE:  if (pending)   nxt = ST_REQ;
      ST_REQ: if (busGrant) begin
        nxt = ST_SETUP;
        strb.ldPhase  = 1'b1;
        strb.phaseSel = PH_SET;
      end
      ST_SETUP: if (phaseZero) begin
        nxt = ST_HOLD;
        strb.ldPhase  = 1'b1;
        strb.phaseSel = PH_HOLD;
      end
      ST_HOLD: if (phaseZero) begin
        nxt = ST_TAIL;
        strb.ldPhase  = 1'b1;
        strb.phaseSel = PH_TAIL;
      end
      ST_TAIL: if (phaseZero) begin
        nxt = ST_PRE;
        strb.ldPhase  = 1'b1;
        strb.phaseSel = PH_PRE;
      end
      ST_PRE: if (phaseZero) begin
        strb.cycleDone = 1'b1;
        strb.rowStep   = modeRasOnly;
        nxt = (!initDone && !initLast) ? ST_REQ : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
    strb.addrEn = modeRasOnly && inCycle;
  end

  assign busReq = inCycle || (st == ST_REQ);
  assign rasN   = !((st == ST_HOLD) || (st == ST_TAIL));
  assign lcasN  = !(!modeRasOnly && ((st == ST_SETUP) || (st == ST_HOLD)));
  assign ucasN  = 1'b1;
  assign weN    = 1'b1;

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pauseDone |-> !busReq);
  // R3
  ras_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> busGrant);
  // R4
  cbr_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !lcasN) |-> !$past(lcasN));
  // R2
  init_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (rasN && !busReq));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_KHZ      = 100000,
  parameter int RETENTION_US = 16000,
  parameter int PAUSE_US     = 200,
  parameter int RATE_MUL     = 8,
  parameter int INIT_CYCLES  = 8,
  parameter int ROW_BITS     = 10,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_CYC      = 6,
  parameter int RP_CYC       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slowRate,
  input  logic                rasOnlyMode,
  input  logic                busGrant,
  output logic                busReq,
  output logic                rasN,
  output logic                ucasN,
  output logic                lcasN,
  output logic                weN,
  output logic [ROW_BITS-1:0] addr,
  output logic                initDone,
  output logic                refreshOverflow
);

  localparam longint ROWS      = longint'(1) << ROW_BITS;
  localparam longint RET_CYC   = longint'(CLK_KHZ) * RETENTION_US / 1000;
  localparam int     INTERVAL  = int'(RET_CYC / ROWS);
  localparam int     PAUSE_CYC = int'(longint'(CLK_KHZ) * PAUSE_US / 1000);

  refStrobe_t strb;
  logic pauseDone, initLast, pending, phaseZero;

  dram_ref_ctl u_ctl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .rasOnlyMode(rasOnlyMode),
    .pauseDone(pauseDone), .initDone(initDone), .initLast(initLast),
    .pending(pending), .phaseZero(phaseZero), .strb(strb),
    .busReq(busReq), .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN), .weN(weN)
  );

  dram_ref_dp #(
    .PAUSE_CYCLES(PAUSE_CYC), .INTERVAL(INTERVAL), .RATE_MUL(RATE_MUL),
    .INIT_CYCLES(INIT_CYCLES), .ROW_BITS(ROW_BITS), .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .slowRate(slowRate), .strb(strb),
    .pauseDone(pauseDone), .initDone(initDone), .initLast(initLast),
    .pending(pending), .phaseZero(phaseZero),
    .refreshOverflow(refreshOverflow), .addr(addr)
  );

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 1000;
  localparam int RET_US     = 40960;
  localparam int PAUSE_US   = 50;
  localparam int RATE_MUL   = 8;
  localparam int INIT_CYC   = 8;
  localparam int INTERVAL   = 40;  // 40960 cycles / 1024 rows
  localparam int PAUSE      = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowRate = 1'b0, rasOnlyMode = 1'b0, busGrant = 1'b0, holdOff = 1'b0;
  logic busReq, rasN, ucasN, lcasN, weN, initDone, refreshOverflow;
  logic [9:0] addr;

  int checks = 0, errors = 0;
  longint cyc = 0;
  int fallCnt = 0;
  longint lastFall = 0, gap = 0;
  logic prevRas = 1'b1, prevLcas = 1'b1;
  logic fallLcas, fallUcas, fallWe, fallGrant, lcasBefore;
  logic [9:0] fallAddr;

  dram_refresh_seq #(
    .CLK_KHZ(CLK_KHZ), .RETENTION_US(RET_US), .PAUSE_US(PAUSE_US),
    .RATE_MUL(RATE_MUL), .INIT_CYCLES(INIT_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .slowRate(slowRate), .rasOnlyMode(rasOnlyMode),
    .busGrant(busGrant), .busReq(busReq), .rasN(rasN), .ucasN(ucasN),
    .lcasN(lcasN), .weN(weN), .addr(addr), .initDone(initDone),
    .refreshOverflow(refreshOverflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) busGrant <= busReq && !holdOff;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !rasN) begin
        fallCnt++;
        gap = cyc - lastFall;
        lastFall = cyc;
        fallLcas = lcasN; fallUcas = ucasN; fallWe = weN;
        fallGrant = busGrant; fallAddr = addr; lcasBefore = prevLcas;
      end
      prevRas = rasN;
      prevLcas = lcasN;
    end
  end

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitFall();
    int start = fallCnt;
    int n = 0;
    while (fallCnt == start && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 refresh cycle seen", fallCnt != start, fallCnt, start + 1);
  endtask

  task automatic checkCbr(input string tag);
    chk({tag, " lcasN low at RAS fall"}, fallLcas == 1'b0, fallLcas, 0);
    chk({tag, " ucasN high"}, fallUcas == 1'b1, fallUcas, 1);
    chk({tag, " lcasN low before RAS fall"}, lcasBefore == 1'b0, lcasBefore, 0);
    chk({tag, " weN high"}, fallWe == 1'b1, fallWe, 1);
    chk("R3 grant held at RAS fall", fallGrant == 1'b1, fallGrant, 1);
  endtask

  task automatic testReset();
    int n = 0;
    repeat (4) @(negedge clk);
    chk("R1 rasN idle", rasN == 1'b1, rasN, 1);
    chk("R1 cas idle", ucasN && lcasN, {ucasN, lcasN}, 3);
    chk("R1 weN idle", weN == 1'b1, weN, 1);
    chk("R1 busReq low", busReq == 1'b0, busReq, 0);
    chk("R1 flags low", !initDone && !refreshOverflow, {initDone, refreshOverflow}, 0);
    chk("R1 addr zero", addr == 10'd0, addr, 0);
    rstN = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!busReq && n < 1000);
    chk("R1 pause length", n >= PAUSE && n <= PAUSE + 3, n, PAUSE);
    chk("R1 no RAS during pause", fallCnt == 0, fallCnt, 0);
  endtask

  task automatic testInit();
    int n = 0;
    for (int i = 0; i < INIT_CYC; i++) begin
      waitFall();
      checkCbr("R4 init");
      if (i < INIT_CYC - 1)
        chk("R2 initDone low mid burst", initDone == 1'b0, initDone, 0);
    end
    while (!initDone && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R2 initDone raised", initDone == 1'b1, initDone, 1);
    chk("R2 init cycle count", fallCnt == INIT_CYC, fallCnt, INIT_CYC);
    chk("R2 rasN high at done", rasN == 1'b1, rasN, 1);
    chk("R2 busReq low at done", busReq == 1'b0, busReq, 0);
  endtask

  task automatic testInterval();
    waitFall();
    waitFall();
    checkCbr("R4 periodic");
    chk("R6 fast spacing", gap == INTERVAL, gap, INTERVAL);
    waitFall();
    chk("R6 fast spacing again", gap == INTERVAL, gap, INTERVAL);
  endtask

  task automatic testSlow();
    slowRate = 1'b1;
    waitFall();
    waitFall();
    waitFall();
    chk("R7 slow spacing", gap == INTERVAL * RATE_MUL, gap, INTERVAL * RATE_MUL);
    slowRate = 1'b0;
    waitFall();
    waitFall();
    waitFall();
    chk("R6 fast spacing restored", gap == INTERVAL, gap, INTERVAL);
  endtask

  task automatic testRasOnly();
    repeat (20) @(negedge clk);
    rasOnlyMode = 1'b1;
    for (int k = 0; k <= 1024; k++) begin
      waitFall();
      if (k < 3 || k >= 1023) begin
        chk("R5 both CAS high", fallUcas && fallLcas, {fallUcas, fallLcas}, 3);
        chk("R5 row address", fallAddr == 10'(k), fallAddr, k % 1024);
      end
    end
    repeat (20) @(negedge clk);
    rasOnlyMode = 1'b0;
    waitFall();
    checkCbr("R4 after RAS-only");
    chk("R5 addr zero in CBR", fallAddr == 10'd0, fallAddr, 0);
  endtask

  task automatic testBlock();
    int start;
    int n = 0;
    waitFall();
    repeat (20) @(negedge clk);
    holdOff = 1'b1;
    start = fallCnt;
    repeat (INTERVAL) @(negedge clk);
    chk("R8 no RAS while blocked", fallCnt == start, fallCnt, start);
    chk("R8 busReq held while pending", busReq == 1'b1, busReq, 1);
    chk("R9 no overflow after one interval", refreshOverflow == 1'b0, refreshOverflow, 0);
    holdOff = 1'b0;
    while (fallCnt == start && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R8 pending refresh served after grant", n <= 10, n, 10);
    checkCbr("R4 after block");
    // second block spanning two expiries
    repeat (20) @(negedge clk);
    holdOff = 1'b1;
    repeat (2 * INTERVAL + 5) @(negedge clk);
    chk("R9 overflow set", refreshOverflow == 1'b1, refreshOverflow, 1);
    holdOff = 1'b0;
    waitFall();
    repeat (INTERVAL) @(negedge clk);
    chk("R9 overflow sticky", refreshOverflow == 1'b1, refreshOverflow, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testInit();
    testInterval();
    testSlow();
    testRasOnly();
    testBlock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule